// File: doc/BRIEF.md
# Programmable Sinc Decimation Stage

This block is the second, run-time configurable filter stage of a delta-sigma converter's decimation chain. It sits behind a fixed fifth-order decimator and receives one signed sample per cycle in which `inValid` is high. From every R accepted samples it produces one output word. A 3-bit rate code selects R from a fixed set of eight ratios. A mode bit selects one of two responses. The first-order response is a plain block average. The second-order response is a triangular weighting over the last 2R-1 samples, built as two cascaded integrators feeding two differencing stages.

Results are scaled back to input full scale by 1/R or 1/R² and rounded to the nearest integer. Each result comes with a one-cycle valid strobe and a settled flag that tells the consumer whether the filter history behind the word is complete. A change of rate code or mode flushes all filter state, so that conversions restart cleanly under the new setting.

Top module: `prog_sinc_decim`

## Requirements
- R1: While `rstN` is low at a clock edge, the following state holds after that edge: `outValid` is 0, `outData` is 0 and `outSettled` is 0.
- R2: Rate code to ratio R: 3'b111→1, 3'b110→4, 3'b101→12, 3'b100→36, 3'b011→240, 3'b010→288, 3'b001→864, 3'b000→1440. Exactly one output is produced per R accepted samples, counted from the last flush. The ratio is the same in both modes.
- R3: With `orderSel`=0, each output equals the sum of the last R accepted samples divided by R.
- R4: With `orderSel`=1, each output equals the sum of w(j)·x[n-j] for j=0..2R-2, divided by R². Here x[n] is the sample that completes the period, w(j)=min(j+1, 2R-1-j), and samples before the last flush count as 0.
- R5: The division in R3 and R4 rounds to the nearest integer, with ties going away from zero.
- R6: `outSettled` is 1 on every output in mode 0. In mode 1 it is 0 on the first output after reset or after a flush, and 1 on every later output.
- R7: A flush happens in any cycle where `rateCode` or `orderSel` differs from its value in the previous cycle. A flush clears the integrators, the differencing stages and the sample counter. The sample offered in that cycle is discarded. No output appears two cycles after a flush.
- R8: With R=1, every accepted sample produces an output two cycles later that equals that sample, in both modes.
- R9: `outValid` is high for exactly one cycle, two clock edges after the edge that accepts the sample completing a period. `outData` and `outSettled` hold their values while `outValid` is low.
- R10: Cycles with `inValid` low change no filter state and do not advance the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input sample strobe |
| inData | input | IN_W | Signed input sample |
| rateCode | input | 3 | Decimation ratio select |
| orderSel | input | 1 | 0 = first-order, 1 = second-order response |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | OUT_W | Signed normalized result |
| outSettled | output | 1 | Result rests on a complete filter history |

## Verification
The bound checker watches several properties on every cycle. It checks the two-edge latency from an accepted sample to the result strobe, and that results hold between strobes. It checks that no result follows a configuration change, that mode-0 results are always flagged settled, and that the R=1 setting passes each sample through unchanged. The arithmetic content of the block can only be shown by the bench's scenarios. This covers the block sums and triangular sums at every ratio and in both modes, rounding at exact ties, full-scale extremes, and a restart after a flush in the middle of a conversion. Each of these is compared against a moving-sum model that the bench computes.

// File: rtl/prog_sinc_pkg.sv
package prog_sinc_pkg;

  // Bits needed to hold the largest ratio (1440 < 2**11)
  localparam int RBITS = 11;

  // Strobes and configuration passed from control to datapath
  typedef struct packed {
    logic       flush;    // configuration changed: clear filter state
    logic       acc;      // sample accepted this cycle
    logic       dump;     // accepted sample completes a conversion period
    logic       settled;  // result of this period rests on full history
    logic       order;    // active response order (0 first, 1 second)
    logic [2:0] rate;     // active rate code
  } ctl_t;

  function automatic int unsigned ratioOf(input logic [2:0] code);
    case (code)
      3'b111:  return 1;
      3'b110:  return 4;
      3'b101:  return 12;
      3'b100:  return 36;
      3'b011:  return 240;
      3'b010:  return 288;
      3'b001:  return 864;
      default: return 1440;
    endcase
  endfunction

endpackage

// File: rtl/prog_sinc_ctrl.sv
module prog_sinc_ctrl
  import prog_sinc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] rateCode,
  input  logic       orderSel,
  output ctl_t       ctl
);

  logic [2:0]       rateQ;
  logic             orderQ;
  logic [RBITS-1:0] sampleCnt;
  logic             seenOne;
  logic             cfgChange;
  logic [RBITS-1:0] lastIdx;

  assign cfgChange = (rateCode != rateQ) || (orderSel != orderQ);
  assign lastIdx   = RBITS'(ratioOf(rateQ) - 1);

  always_comb begin
    ctl.flush   = cfgChange;
    ctl.acc     = inValid && !cfgChange;
    ctl.dump    = inValid && !cfgChange && (sampleCnt == lastIdx);
    ctl.settled = !orderQ || seenOne;
    ctl.order   = orderQ;
    ctl.rate    = rateQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ     <= rateCode;
      orderQ    <= orderSel;
      sampleCnt <= '0;
      seenOne   <= 1'b0;
    end else if (cfgChange) begin
      rateQ     <= rateCode;
      orderQ    <= orderSel;
      sampleCnt <= '0;
      seenOne   <= 1'b0;
    end else if (inValid) begin
      if (sampleCnt == lastIdx) begin
        sampleCnt <= '0;
        seenOne   <= 1'b1;
      end else begin
        sampleCnt <= sampleCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/prog_sinc_dp.sv
module prog_sinc_dp
  import prog_sinc_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [OUT_W-1:0] outData,
  output logic             outSettled
);

  // Accumulator width covers worst-case gain R^2 < 2**(2*RBITS)
  localparam int ACC_W = IN_W + 2 * RBITS;
  // Reciprocal shift: exact rounding needs 2*|y|*D < 2**SH
  localparam int SH    = IN_W + 4 * RBITS;
  localparam int KW    = SH + 1;
  localparam int NW    = KW + 1;
  localparam int PW    = ACC_W + KW;
  localparam logic [PW-1:0] POS_MAX = (PW'(1) << (OUT_W - 1)) - PW'(1);
  localparam logic [PW-1:0] NEG_MAG = PW'(1) << (OUT_W - 1);
  localparam logic [PW-1:0] HALF    = PW'(1) << (SH - 1);

  // ceil(2**SH / D) for table index {order, code}
  function automatic logic [KW-1:0] recipOf(input int idx);
    logic [NW-1:0] num;
    logic [NW-1:0] den;
    int unsigned   r;
    r   = ratioOf(idx[2:0]);
    den = (idx >= 8) ? NW'(r) * NW'(r) : NW'(r);
    num = (NW'(1) << SH) + den - NW'(1);
    return KW'(num / den);
  endfunction

  logic [KW-1:0] kTab [16];

  for (genvar g = 0; g < 16; g++) begin : g_recip
    localparam logic [KW-1:0] KVAL = recipOf(g);
    assign kTab[g] = KVAL;
  end

  // Integrator and differencing state (wrap-around arithmetic)
  logic [ACC_W-1:0] integ1, integ2, dly1, dly2;
  logic [ACC_W-1:0] xExt, integ1Nxt, integ2Nxt, combSrc, comb1, comb2;
  logic [ACC_W-1:0] sumQ;
  logic [3:0]       kIdxQ;
  logic             sumValid, sumSettled;

  assign xExt      = {{(ACC_W - IN_W){inData[IN_W-1]}}, inData};
  assign integ1Nxt = integ1 + xExt;
  assign integ2Nxt = integ2 + integ1Nxt;
  assign combSrc   = ctl.order ? integ2Nxt : integ1Nxt;
  assign comb1     = combSrc - dly1;
  assign comb2     = comb1 - dly2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      integ1     <= '0;
      integ2     <= '0;
      dly1       <= '0;
      dly2       <= '0;
      sumQ       <= '0;
      kIdxQ      <= '0;
      sumValid   <= 1'b0;
      sumSettled <= 1'b0;
    end else begin
      if (ctl.flush) begin
        integ1 <= '0;
        integ2 <= '0;
        dly1   <= '0;
        dly2   <= '0;
      end else if (ctl.acc) begin
        integ1 <= integ1Nxt;
        integ2 <= integ2Nxt;
        if (ctl.dump) begin
          dly1  <= combSrc;
          dly2  <= comb1;
          sumQ  <= ctl.order ? comb2 : comb1;
          kIdxQ <= {ctl.order, ctl.rate};
        end
      end
      sumValid <= ctl.dump;
      if (ctl.dump) sumSettled <= ctl.settled;
    end
  end

  // Normalization: sign-magnitude reciprocal multiply, round half away from zero
  logic             sumNeg;
  logic [ACC_W-1:0] magV;
  logic [PW-1:0]    prodV, quotV;
  logic [OUT_W-1:0] normV;

  always_comb begin
    sumNeg = sumQ[ACC_W-1];
    magV   = sumNeg ? (~sumQ + 1'b1) : sumQ;
    prodV  = PW'(magV) * PW'(kTab[kIdxQ]);
    quotV  = (prodV + HALF) >> SH;
    if (sumNeg) begin
      if (quotV > NEG_MAG) normV = {1'b1, {(OUT_W - 1){1'b0}}};
      else                 normV = OUT_W'(~quotV + 1'b1);
    end else begin
      if (quotV > POS_MAX) normV = {1'b0, {(OUT_W - 1){1'b1}}};
      else                 normV = OUT_W'(quotV);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outSettled <= 1'b0;
    end else begin
      outValid <= sumValid;
      if (sumValid) begin
        outData    <= normV;
        outSettled <= sumSettled;
      end
    end
  end

endmodule

// File: rtl/prog_sinc_decim.sv
module prog_sinc_decim
  import prog_sinc_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  input  logic [2:0]       rateCode,
  input  logic             orderSel,
  output logic             outValid,
  output logic [OUT_W-1:0] outData,
  output logic             outSettled
);

  ctl_t ctl;

  prog_sinc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rateCode (rateCode),
    .orderSel (orderSel),
    .ctl      (ctl)
  );

  prog_sinc_dp #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .inData     (inData),
    .outValid   (outValid),
    .outData    (outData),
    .outSettled (outSettled)
  );

endmodule

// File: rtl/prog_sinc_chk.sv
module prog_sinc_chk #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [IN_W-1:0]  inData,
  input logic [2:0]       rateCode,
  input logic             orderSel,
  input logic             outValid,
  input logic [OUT_W-1:0] outData,
  input logic             outSettled
);

  // R9
  out_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outData) && $stable(outSettled)));

  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({rateCode, orderSel}) |-> ##2 !outValid);

  // R6
  first_order_settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(orderSel, 2)) |-> outSettled);

  // R8
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rateCode == 3'b111 && $stable(rateCode) && $stable(orderSel))
      |-> ##2 (outValid && $signed(outData) == $signed($past(inData, 2))));

endmodule

bind prog_sinc_decim prog_sinc_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (.*);

// File: tb/prog_sinc_decim_tb_top.sv
module prog_sinc_decim_tb_top;

  localparam int IN_W  = 24;
  localparam int OUT_W = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [IN_W-1:0]  inData = '0;
  logic [2:0]       rateCode = 3'b111;
  logic             orderSel = 1'b0;
  logic             outValid;
  logic [OUT_W-1:0] outData;
  logic             outSettled;

  prog_sinc_decim #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .rateCode(rateCode), .orderSel(orderSel),
    .outValid(outValid), .outData(outData), .outSettled(outSettled)
  );

  always #10 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc++;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    longint val;
    bit     settled;
    longint due;
    string  tag;
  } exp_t;

  exp_t  expQ[$];
  int    hist[$];
  int    mR = 1;
  bit    mMode = 1'b0;
  int    mCnt = 0;
  int    mOut = 0;
  string phaseTag = "";
  exp_t  seen;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int refRatio(input logic [2:0] c);
    case (c)
      3'b111:  return 1;
      3'b110:  return 4;
      3'b101:  return 12;
      3'b100:  return 36;
      3'b011:  return 240;
      3'b010:  return 288;
      3'b001:  return 864;
      default: return 1440;
    endcase
  endfunction

  function automatic int randData();
    int r;
    r = int'($urandom);
    return r >>> (32 - IN_W);
  endfunction

  // Moving-sum reference model
  task automatic modelAccept(input int x, input longint due);
    longint y, d, mag, q;
    int     idx, w;
    exp_t   e;
    hist.push_back(x);
    if (hist.size() > 4096) void'(hist.pop_front());
    mCnt++;
    if (mCnt == mR) begin
      mCnt = 0;
      y = 0;
      if (!mMode) begin
        for (int j = 0; j < mR; j++) begin
          idx = hist.size() - 1 - j;
          if (idx >= 0) y += longint'(hist[idx]);
        end
        d = mR;
      end else begin
        for (int j = 0; j < 2 * mR - 1; j++) begin
          idx = hist.size() - 1 - j;
          w   = (j < mR) ? j + 1 : 2 * mR - 1 - j;
          if (idx >= 0) y += longint'(w) * longint'(hist[idx]);
        end
        d = longint'(mR) * longint'(mR);
      end
      mag = (y < 0) ? -y : y;
      q   = (2 * mag + d) / (2 * d);
      e.val     = (y < 0) ? -q : q;
      e.settled = !mMode || (mOut > 0);
      e.due     = due;
      if (phaseTag != "")  e.tag = phaseTag;
      else if (mR == 1)    e.tag = "R8";
      else if (mMode)      e.tag = "R4";
      else                 e.tag = "R3";
      expQ.push_back(e);
      mOut++;
    end
  endtask

  task automatic drive(input bit v, input int x);
    @(negedge clk);
    inValid = v;
    inData  = IN_W'(x);
    if (v) modelAccept(x, cyc + 2);
  endtask

  task automatic setCfg(input logic [2:0] code, input bit mode, input bit v, input int x);
    @(negedge clk);
    rateCode = code;
    orderSel = mode;
    inValid  = v;      // R7: a sample offered with the change is discarded
    inData   = IN_W'(x);
    hist.delete();
    mCnt  = 0;
    mOut  = 0;
    mR    = refRatio(code);
    mMode = mode;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(1'b0, 0);
  endtask

  // R2: every expected output has arrived and none is missing
  task automatic endPhase();
    idle(6);
    check(expQ.size() == 0, "R2", expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic runRandom(input logic [2:0] code, input bit mode, input int pct, input int nSamp);
    int acc;
    bit v;
    setCfg(code, mode, 1'b0, 0);
    acc = 0;
    while (acc < nSamp) begin
      v = ($urandom % 100) < pct;
      if (v) acc++;
      drive(v, randData());
    end
    endPhase();
  endtask

  // Output monitor: value (R3/R4/R5/R7/R8), settled flag (R6), timing (R9)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", 1, 0);
      end else begin
        seen = expQ.pop_front();
        check(longint'($signed(outData)) == seen.val, seen.tag, longint'($signed(outData)), seen.val);
        check(outSettled == seen.settled, "R6", outSettled, seen.settled);
        check(cyc == seen.due, "R9", cyc, seen.due);
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 190000);
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", outValid, 0);
    check(outData == '0, "R1", longint'(outData), 0);
    check(outSettled == 1'b0, "R1", outSettled, 0);
    @(negedge clk);
    rstN = 1'b1;
    mR = 1;
    mMode = 1'b0;
    idle(3);
    check(outValid == 1'b0, "R1", outValid, 0);

    // R2 R3 R4 R8 R10: every ratio in both modes, random data and gaps
    for (int m = 0; m < 2; m++) begin
      for (int c = 7; c >= 0; c--) begin
        int r;
        r = refRatio(3'(c));
        runRandom(3'(c), m[0], 70, 3 * r + r / 2 + 2);
      end
    end

    // R5: exact ties, first-order R=4
    phaseTag = "R5";
    setCfg(3'b110, 1'b0, 1'b0, 0);
    drive(1, 1);  drive(1, 1);  drive(1, 0);  drive(1, 0);   // 0.5  -> 1
    drive(1, -1); drive(1, -1); drive(1, 0);  drive(1, 0);   // -0.5 -> -1
    drive(1, 2);  drive(1, 0);  drive(1, 0);  drive(1, 0);   // 0.5  -> 1
    drive(1, -3); drive(1, -3); drive(1, 0);  drive(1, 0);   // -1.5 -> -2
    drive(1, 3);  drive(1, 0);  drive(1, 0);  drive(1, 0);   // 0.75 -> 1
    endPhase();

    // R4: full-scale extremes, second-order R=36
    phaseTag = "R4";
    setCfg(3'b100, 1'b1, 1'b0, 0);
    for (int i = 0; i < 108; i++) drive(1, (1 << (IN_W - 1)) - 1);
    for (int i = 0; i < 108; i++) drive(1, -(1 << (IN_W - 1)));
    endPhase();

    // R7: change in mid-conversion, sample offered with the change is dropped
    phaseTag = "R7";
    setCfg(3'b101, 1'b1, 1'b0, 0);
    for (int i = 0; i < 5; i++) drive(1, randData());
    setCfg(3'b110, 1'b1, 1'b1, 12345);
    for (int i = 0; i < 12; i++) drive(1, randData());
    setCfg(3'b110, 1'b0, 1'b1, -777);
    for (int i = 0; i < 9; i++) drive(1, randData());
    endPhase();

    // R10: sparse input strobes
    phaseTag = "R10";
    runRandom(3'b101, 1'b0, 20, 40);
    runRandom(3'b110, 1'b1, 15, 24);
    phaseTag = "";

    finishRun();
  end

endmodule